// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Front End

This block sits between two half-rate sample sources and the digital input of a high-speed digital-to-analog converter core. Each source presents one 14-bit code per data period on its own port. The block captures both ports in input registers, picks between them with a 2:1 selector, and drives the converter code from an output register. The samples reach the output in their original order: port 1 holds the odd-numbered samples and port 2 the even-numbered ones.

A 2-bit mode input selects one of four arrangements. In two of them both ports are interleaved. In the other two only one port passes through. The mode is sampled once, on the first rising clock edge after reset is released, and it stays fixed until the next reset. The outputs hold zero until the first captured sample reaches the output register. After that, each output code lags its port data by a fixed two rising edges.

Top module: `dac_interleave_fe`

## Requirements
- R1: While `rst_ni` is low, `code_o` and `code_late_o` are zero.
- R2: The mode is taken from `mode_i` at the first rising edge after reset release. Later changes of `mode_i` have no effect until the next reset. Encoding: 00 interleave on a double-rate clock, 01 interleave on a data-rate clock, 10 port 1 only, 11 port 2 only.
- R3: In mode 00 the ports are captured together on the second edge after release and then on every other edge. The output alternates port 1 then port 2 of each captured pair, starting with port 1.
- R4: A port sample captured on rising edge n appears on `code_o` after edge n+1. With the first capture on edge 1 (edge 0 being the configuration edge), the first sample shows after edge 2.
- R5: In mode 01 both ports are captured on every edge from edge 1. After the next edge, `code_o` carries the port 1 sample and `code_late_o` the port 2 sample. `code_late_o` is the code for the second half of the data period.
- R6: In mode 10, `code_o` follows `port_a_i` with the R4 latency, and `port_b_i` has no effect.
- R7: In mode 11, `code_o` follows `port_b_i` with the R4 latency, and `port_a_i` has no effect.
- R8: `code_late_o` stays zero in every mode except 01.
- R9: After reset release both outputs stay zero until the first captured sample reaches the output register, which happens at edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Arrangement select, sampled after reset (R2) |
| port_a_i | input | 14 | Port 1 samples (odd-numbered) |
| port_b_i | input | 14 | Port 2 samples (even-numbered) |
| code_o | output | 14 | Converter code |
| code_late_o | output | 14 | Second-half code in mode 01, else zero |

## Verification
The assertions assume that port data is stable across every capture edge. In mode 00 this means each port pair is held for two clocks, aligned so that the pair is present at the capture edge. The bench sets each port value just after a falling edge. In mode 00 it draws a new random pair only on odd cycle indices and repeats that pair on the following even index, so every pair spans one capture edge. It also changes `mode_i` after the configuration edge to show that the latched arrangement is kept.

// File: rtl/dac_il_pkg.sv
package dac_il_pkg;
  typedef enum logic [1:0] {
    MODE_IL_2X = 2'b00,
    MODE_IL_1X = 2'b01,
    MODE_P1    = 2'b10,
    MODE_P2    = 2'b11
  } fe_mode_e;
endpackage

// File: rtl/dac_il_ctrl.sv
module dac_il_ctrl
  import dac_il_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic [1:0] mode_i,
  output fe_mode_e mode_o,
  output logic     phase_o,
  output logic     cap_o,
  output logic     vld_o
);
  fe_mode_e mode_q;
  logic     run_q, phase_q, vld_q;

  // Capture on every edge, except in mode 00 where only phase 0 edges capture.
  assign cap_o = run_q && ((mode_q != MODE_IL_2X) || !phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_IL_2X;
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (!run_q) begin
        mode_q <= fe_mode_e'(mode_i);
        run_q  <= 1'b1;
      end
      if (run_q && mode_q == MODE_IL_2X) phase_q <= ~phase_q;
      if (cap_o) vld_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign phase_o = phase_q;
  assign vld_o   = vld_q;

  a_r2_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> (mode_q == $past(mode_q)));

  a_r3_phase_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode_q == MODE_IL_2X) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/dac_il_in_reg.sv
module dac_il_in_reg #(
  parameter int unsigned DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= d_i;
  end

  assign q_o = q_q;

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));
endmodule

// File: rtl/dac_il_out_stage.sv
module dac_il_out_stage
  import dac_il_pkg::*;
#(
  parameter int unsigned DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fe_mode_e      mode_i,
  input  logic          phase_i,
  input  logic          vld_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] code_o,
  output logic [DW-1:0] late_o
);
  logic [DW-1:0] sel_d, late_d, code_q, late_q;
  logic          filled_q;

  always_comb begin
    late_d = '0;
    unique case (mode_i)
      MODE_IL_2X: sel_d = phase_i ? a_i : b_i;
      MODE_IL_1X: begin
        sel_d  = a_i;
        late_d = b_i;
      end
      MODE_P1:    sel_d = a_i;
      default:    sel_d = b_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      late_q   <= '0;
      filled_q <= 1'b0;
    end else if (vld_i) begin
      code_q   <= sel_d;
      late_q   <= late_d;
      filled_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign late_o = late_q;

  a_r3_port1_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IL_2X && vld_i && phase_i) |=> (code_o == $past(a_i)));

  a_r5_late_port2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IL_1X && vld_i) |=> (late_o == $past(b_i)));

  a_r6_port1_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_P1 && vld_i) |=> (code_o == $past(a_i)));

  a_r7_port2_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_P2 && vld_i) |=> (code_o == $past(b_i)));

  a_r8_late_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_IL_1X) |-> (late_o == '0));

  a_r9_zero_unfilled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filled_q |-> (code_o == '0 && late_o == '0));
endmodule

// File: rtl/dac_interleave_fe.sv
module dac_interleave_fe
  import dac_il_pkg::*;
#(
  parameter int unsigned DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] port_a_i,
  input  logic [DW-1:0] port_b_i,
  output logic [DW-1:0] code_o,
  output logic [DW-1:0] code_late_o
);
  localparam int unsigned NPORT = 2;

  fe_mode_e      mode;
  logic          phase, cap, vld;
  logic [DW-1:0] port_d [NPORT];
  logic [DW-1:0] port_q [NPORT];

  assign port_d[0] = port_a_i;
  assign port_d[1] = port_b_i;

  dac_il_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .mode_o  (mode),
    .phase_o (phase),
    .cap_o   (cap),
    .vld_o   (vld)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dac_il_in_reg #(.DW(DW)) u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cap),
      .d_i    (port_d[p]),
      .q_o    (port_q[p])
    );
  end

  dac_il_out_stage #(.DW(DW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .phase_i (phase),
    .vld_i   (vld),
    .a_i     (port_q[0]),
    .b_i     (port_q[1]),
    .code_o  (code_o),
    .late_o  (code_late_o)
  );

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0 && code_late_o == '0));
endmodule

// File: tb/tb_dac_interleave_fe.sv
module tb_dac_interleave_fe;
  localparam int DW = 14;
  localparam int N  = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [DW-1:0] port_a_i = '0, port_b_i = '0;
  logic [DW-1:0] code_o, code_late_o;

  logic [DW-1:0] pa [N];
  logic [DW-1:0] pb [N];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_interleave_fe dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .port_a_i(port_a_i), .port_b_i(port_b_i),
    .code_o(code_o), .code_late_o(code_late_o)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_code(logic [1:0] m, int k);
    if (k < 2) return '0;
    case (m)
      2'b00:   return (k % 2 == 0) ? pa[k-1] : pb[k-2];
      2'b01:   return pa[k-1];
      2'b10:   return pa[k-1];
      default: return pb[k-1];
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_late(logic [1:0] m, int k);
    if (k < 2 || m != 2'b01) return '0;
    return pb[k-1];
  endfunction

  function automatic string tag(logic [1:0] m, int k, bit chg);
    if (k < 2)  return "R9";
    if (k == 2) return "R4";
    if (chg)    return "R2";
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_mode(logic [1:0] m, bit chg);
    for (int i = 0; i < N; i++) begin
      pa[i] = DW'($urandom);
      pb[i] = DW'($urandom);
    end
    pa[3] = '0;         pb[3] = {DW{1'b1}};
    pa[5] = {DW{1'b1}}; pb[5] = '0;
    if (m == 2'b00)
      for (int i = 2; i < N; i += 2) begin
        pa[i] = pa[i-1];
        pb[i] = pb[i-1];
      end
    @(negedge clk);
    rst_ni   = 1'b0;
    mode_i   = m;
    port_a_i = DW'($urandom);
    port_b_i = DW'($urandom);
    @(negedge clk);
    @(negedge clk);
    check("R1", code_o, '0);
    check("R1", code_late_o, '0);
    rst_ni   = 1'b1;
    port_a_i = pa[0];
    port_b_i = pb[0];
    for (int k = 0; k < N; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(tag(m, k, chg), code_o, exp_code(m, k));
      check((m == 2'b01) ? tag(m, k, chg) : "R8", code_late_o, exp_late(m, k));
      if (chg && k == 0) mode_i = ~m;
      if (k + 1 < N) begin
        port_a_i = pa[k+1];
        port_b_i = pb[k+1];
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C3A));
    run_mode(2'b00, 1'b0);
    run_mode(2'b01, 1'b0);
    run_mode(2'b10, 1'b1);
    run_mode(2'b11, 1'b0);
    run_mode(2'b00, 1'b1);
    run_mode(2'b11, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule